// File: doc/BRIEF.md
# Tag-Capturing Reservation Station Pool

This block holds instructions that have been issued but not yet completed, for two classes of execution unit: an add/subtract class and a multiply/divide class. Every station records whether it is occupied, the operation, two operand values and, for each operand that is not yet known, the tag of the station that will produce it. A single result bus carries one finished result per cycle, labelled with the producing station's tag. Each waiting station compares its pending tags against that bus and takes the value when they match.

An upstream renamer issues one operation per cycle through the issue port and learns from the block which station tag it received. Once both operands of a station are known, the station is handed to its class's unit, which is not pipelined and takes a fixed number of cycles that depends on the operation. The unit then competes for the result bus. A station stays occupied until its own result is broadcast. The units compute integer stand-ins for the arithmetic.

Top module: `rs_pool`

## Requirements
- R1: After reset all stations are free: `issue_ready` is high for every operation code, and no dispatch or broadcast occurs until something has been issued.
- R2: Operation codes are 0 add, 1 subtract, 2 multiply, 3 divide. Add and subtract go to stations with tags 1 to N_ADD. Multiply and divide go to tags N_ADD+1 to N_ADD+N_MUL. Tag 0 means "value present". An accepted issue takes the lowest-numbered free station of its class, and `issue_tag` reports that tag (0 when none is free).
- R3: When every station of the operation's class is occupied, `issue_ready` is low. An issue presented then is dropped and has no effect.
- R4: An operand issued with a nonzero tag waits. In a cycle where `cdb_valid` is high and `cdb_tag` equals that tag, every station waiting on it takes `cdb_value` for that operand and stops waiting.
- R5: A station with both operands present at issue may dispatch in the cycle after issue. A station that obtains its last operand from the bus dispatches no earlier than the cycle after the broadcast.
- R6: Among ready stations of one class, the one issued earliest dispatches first, whatever its tag.
- R7: A result is broadcast at the earliest LAT cycles after its dispatch cycle. LAT is 2 for add/subtract, 10 for multiply and 40 for divide.
- R8: Each unit holds one operation at a time, including while it waits for the bus. A class therefore never dispatches in two consecutive cycles.
- R9: At most one result is broadcast per cycle. When both units have a result, the lower tag goes first and the other is held for the next cycle.
- R10: A station stays occupied until the cycle in which its result is broadcast, and is free for issue from the following cycle.
- R11: Results on the 16-bit bus are: a+b, a-b and the low DW bits of a*b, all modulo 2^DW, and the unsigned quotient a/b. Division by zero yields all ones.
- R12: An operand issued with a tag that is being broadcast in that same cycle takes the broadcast value at issue.
- R13: Both classes may dispatch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue request this cycle |
| issue_op | input | 2 | Operation code (0 add, 1 sub, 2 mul, 3 div) |
| issue_vj | input | DW | First operand value, used when issue_qj is 0 |
| issue_qj | input | TW | First operand producer tag, 0 if value given |
| issue_vk | input | DW | Second operand value, used when issue_qk is 0 |
| issue_qk | input | TW | Second operand producer tag, 0 if value given |
| issue_ready | output | 1 | A station of the requested class is free |
| issue_tag | output | TW | Tag of the station an issue would take |
| add_disp_valid | output | 1 | Add/subtract class dispatches this cycle |
| add_disp_tag | output | TW | Tag of the dispatching add/subtract station |
| mul_disp_valid | output | 1 | Multiply/divide class dispatches this cycle |
| mul_disp_tag | output | TW | Tag of the dispatching multiply/divide station |
| cdb_valid | output | 1 | Result broadcast this cycle |
| cdb_tag | output | TW | Tag of the broadcasting station |
| cdb_value | output | DW | Broadcast result value |

## Verification
The bench builds the block with its default values: three add/subtract stations, two multiply/divide stations, 16-bit data and latencies of 2, 10 and 40. With these values the divide chain is long enough to keep the multiply class full for dozens of cycles, which brings the stall and the release cycle of R3 and R10 within reach. The 10-cycle multiply can be lined up to finish in the same cycle as a later add, which exercises the bus conflict of R9. Directed sequences also place a younger operation in a lower-numbered station to exercise R6, and issue an operand in the same cycle as its broadcast for R12. A random phase then issues operations whose producer tags are drawn from the stations the reference model currently holds.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    // Operation encoding seen at the issue port.
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } rs_op_e;

    // Tag value meaning "operand already present".
    localparam int TAG_NONE = 0;

    function automatic logic op_is_muldiv(input rs_op_e op);
        return (op == OP_MUL) || (op == OP_DIV);
    endfunction

    function automatic int op_latency(input rs_op_e op, input int lat_add,
                                      input int lat_mul, input int lat_div);
        case (op)
            OP_MUL:  return lat_mul;
            OP_DIV:  return lat_div;
            default: return lat_add;
        endcase
    endfunction

endpackage

// File: rtl/rs_entry.sv
module rs_entry
    import rsp_pkg::*;
#(
    parameter int DW     = 16,
    parameter int TW     = 3,
    parameter int MY_TAG = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  rs_op_e        alloc_op,
    input  logic [DW-1:0] alloc_vj,
    input  logic [TW-1:0] alloc_qj,
    input  logic [DW-1:0] alloc_vk,
    input  logic [TW-1:0] alloc_qk,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tag,
    input  logic [DW-1:0] cdb_value,
    input  logic          take,
    output logic          busy,
    output logic          ready,
    output rs_op_e        ent_op,
    output logic [DW-1:0] ent_vj,
    output logic [DW-1:0] ent_vk
);

    typedef struct packed {
        logic          busy;
        logic          sent;
        rs_op_e        op;
        logic [DW-1:0] vj;
        logic [DW-1:0] vk;
        logic [TW-1:0] qj;
        logic [TW-1:0] qk;
    } slot_t;

    localparam logic [TW-1:0] SELF = TW'(MY_TAG);
    localparam logic [TW-1:0] NONE = TW'(TAG_NONE);

    slot_t s;

    logic hit_j, hit_k, new_hit_j, new_hit_k, self_done;

    // Match of a stored wait tag against the bus.
    assign hit_j     = cdb_valid && (s.qj != NONE) && (s.qj == cdb_tag);
    assign hit_k     = cdb_valid && (s.qk != NONE) && (s.qk == cdb_tag);
    // Match of an incoming wait tag against the bus in the issue cycle.
    assign new_hit_j = cdb_valid && (alloc_qj != NONE) && (alloc_qj == cdb_tag);
    assign new_hit_k = cdb_valid && (alloc_qk != NONE) && (alloc_qk == cdb_tag);
    assign self_done = s.busy && cdb_valid && (cdb_tag == SELF);

    always_ff @(posedge clk) begin
        if (rst) begin
            s <= '0;
        end else if (alloc) begin
            s.busy <= 1'b1;
            s.sent <= 1'b0;
            s.op   <= alloc_op;
            s.vj   <= new_hit_j ? cdb_value : alloc_vj;
            s.qj   <= new_hit_j ? NONE : alloc_qj;
            s.vk   <= new_hit_k ? cdb_value : alloc_vk;
            s.qk   <= new_hit_k ? NONE : alloc_qk;
        end else begin
            if (self_done) begin
                s.busy <= 1'b0;
            end
            if (s.busy && hit_j) begin
                s.vj <= cdb_value;
                s.qj <= NONE;
            end
            if (s.busy && hit_k) begin
                s.vk <= cdb_value;
                s.qk <= NONE;
            end
            if (take) begin
                s.sent <= 1'b1;
            end
        end
    end

    // Readiness uses registered state only, so a value captured this cycle
    // makes the entry eligible one cycle later.
    assign busy   = s.busy;
    assign ready  = s.busy && !s.sent && (s.qj == NONE) && (s.qk == NONE);
    assign ent_op = s.op;
    assign ent_vj = s.vj;
    assign ent_vk = s.vk;

endmodule

// File: rtl/rs_class.sv
module rs_class
    import rsp_pkg::*;
#(
    parameter int N    = 3,
    parameter int BASE = 1,
    parameter int DW   = 16,
    parameter int TW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_req,
    input  rs_op_e        alloc_op,
    input  logic [DW-1:0] alloc_vj,
    input  logic [TW-1:0] alloc_qj,
    input  logic [DW-1:0] alloc_vk,
    input  logic [TW-1:0] alloc_qk,
    output logic          has_free,
    output logic [TW-1:0] free_tag,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tag,
    input  logic [DW-1:0] cdb_value,
    input  logic          unit_idle,
    output logic          disp_valid,
    output logic [TW-1:0] disp_tag,
    output rs_op_e        disp_op,
    output logic [DW-1:0] disp_a,
    output logic [DW-1:0] disp_b
);

    logic [N-1:0]  busy_v, ready_v, free_pick, alloc_v, win_v, take_v;
    rs_op_e        op_a [N];
    logic [DW-1:0] vj_a [N];
    logic [DW-1:0] vk_a [N];
    // older[i][j] set: entry i was issued before entry j.
    logic [N-1:0]  older [N];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            rs_entry #(
                .DW(DW), .TW(TW), .MY_TAG(BASE + g)
            ) u_ent (
                .clk      (clk),
                .rst      (rst),
                .alloc    (alloc_v[g]),
                .alloc_op (alloc_op),
                .alloc_vj (alloc_vj),
                .alloc_qj (alloc_qj),
                .alloc_vk (alloc_vk),
                .alloc_qk (alloc_qk),
                .cdb_valid(cdb_valid),
                .cdb_tag  (cdb_tag),
                .cdb_value(cdb_value),
                .take     (take_v[g]),
                .busy     (busy_v[g]),
                .ready    (ready_v[g]),
                .ent_op   (op_a[g]),
                .ent_vj   (vj_a[g]),
                .ent_vk   (vk_a[g])
            );
        end
    endgenerate

    // Lowest-numbered free entry.
    always_comb begin
        free_pick = '0;
        has_free  = 1'b0;
        free_tag  = '0;
        for (int i = 0; i < N; i++) begin
            if (!busy_v[i] && !has_free) begin
                has_free     = 1'b1;
                free_pick[i] = 1'b1;
                free_tag     = TW'(BASE + i);
            end
        end
    end

    assign alloc_v = alloc_req ? free_pick : '0;

    // Age matrix: a new entry is younger than every current one.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                older[i] <= '0;
            end
        end else begin
            for (int k = 0; k < N; k++) begin
                if (alloc_v[k]) begin
                    for (int j = 0; j < N; j++) begin
                        if (j != k) begin
                            older[k][j] <= 1'b0;
                            older[j][k] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Oldest ready entry wins.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            win_v[i] = ready_v[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && ready_v[j] && !older[i][j]) begin
                    win_v[i] = 1'b0;
                end
            end
        end
    end

    assign take_v     = unit_idle ? win_v : '0;
    assign disp_valid = |take_v;

    always_comb begin
        disp_tag = '0;
        disp_op  = OP_ADD;
        disp_a   = '0;
        disp_b   = '0;
        for (int i = 0; i < N; i++) begin
            if (win_v[i]) begin
                disp_tag = TW'(BASE + i);
                disp_op  = op_a[i];
                disp_a   = vj_a[i];
                disp_b   = vk_a[i];
            end
        end
    end

endmodule

// File: rtl/fu_unit.sv
module fu_unit
    import rsp_pkg::*;
#(
    parameter int DW     = 16,
    parameter int TW     = 3,
    parameter bit MULDIV = 1'b0,
    parameter int LAT_A  = 2,
    parameter int LAT_M  = 10,
    parameter int LAT_D  = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  rs_op_e        op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [TW-1:0] tag,
    input  logic          grant,
    output logic          idle,
    output logic          done,
    output logic [TW-1:0] res_tag,
    output logic [DW-1:0] res_value
);

    localparam int LMAX0 = (LAT_A > LAT_M) ? LAT_A : LAT_M;
    localparam int LMAX  = (LMAX0 > LAT_D) ? LMAX0 : LAT_D;
    localparam int CW    = $clog2(LMAX + 1);

    logic          busy;
    logic [CW-1:0] cnt;
    logic [DW-1:0] result;
    int            lat;

    generate
        if (MULDIV) begin : g_muldiv
            always_comb begin
                if (op == OP_DIV) begin
                    result = (b == '0) ? '1 : (a / b);
                end else begin
                    result = a * b;
                end
            end
        end else begin : g_addsub
            always_comb begin
                result = (op == OP_SUB) ? (a - b) : (a + b);
            end
        end
    endgenerate

    assign lat = op_latency(op, LAT_A, LAT_M, LAT_D);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            res_tag   <= '0;
            res_value <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            cnt       <= CW'(lat - 1);
            res_tag   <= tag;
            res_value <= result;
        end else if (busy) begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else if (grant) begin
                busy <= 1'b0;
            end
        end
    end

    assign idle = !busy;
    assign done = busy && (cnt == '0);

endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rsp_pkg::*;
#(
    parameter int N_ADD   = 3,
    parameter int N_MUL   = 2,
    parameter int DW      = 16,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40,
    localparam int TW     = $clog2(N_ADD + N_MUL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_valid,
    input  logic [1:0]    issue_op,
    input  logic [DW-1:0] issue_vj,
    input  logic [TW-1:0] issue_qj,
    input  logic [DW-1:0] issue_vk,
    input  logic [TW-1:0] issue_qk,
    output logic          issue_ready,
    output logic [TW-1:0] issue_tag,
    output logic          add_disp_valid,
    output logic [TW-1:0] add_disp_tag,
    output logic          mul_disp_valid,
    output logic [TW-1:0] mul_disp_tag,
    output logic          cdb_valid,
    output logic [TW-1:0] cdb_tag,
    output logic [DW-1:0] cdb_value
);

    rs_op_e        op_in;
    logic          to_mul;
    logic          a_free, m_free;
    logic [TW-1:0] a_free_tag, m_free_tag;
    logic          a_idle, m_idle, a_done, m_done;
    logic          a_grant, m_grant, pick_add;
    logic [TW-1:0] a_res_tag, m_res_tag;
    logic [DW-1:0] a_res_val, m_res_val;
    rs_op_e        a_op, m_op;
    logic [DW-1:0] a_a, a_b, m_a, m_b;

    assign op_in       = rs_op_e'(issue_op);
    assign to_mul      = op_is_muldiv(op_in);
    assign issue_ready = to_mul ? m_free : a_free;
    assign issue_tag   = to_mul ? m_free_tag : a_free_tag;

    rs_class #(.N(N_ADD), .BASE(1), .DW(DW), .TW(TW)) u_add_rs (
        .clk       (clk),
        .rst       (rst),
        .alloc_req (issue_valid && !to_mul),
        .alloc_op  (op_in),
        .alloc_vj  (issue_vj),
        .alloc_qj  (issue_qj),
        .alloc_vk  (issue_vk),
        .alloc_qk  (issue_qk),
        .has_free  (a_free),
        .free_tag  (a_free_tag),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_value (cdb_value),
        .unit_idle (a_idle),
        .disp_valid(add_disp_valid),
        .disp_tag  (add_disp_tag),
        .disp_op   (a_op),
        .disp_a    (a_a),
        .disp_b    (a_b)
    );

    rs_class #(.N(N_MUL), .BASE(N_ADD + 1), .DW(DW), .TW(TW)) u_mul_rs (
        .clk       (clk),
        .rst       (rst),
        .alloc_req (issue_valid && to_mul),
        .alloc_op  (op_in),
        .alloc_vj  (issue_vj),
        .alloc_qj  (issue_qj),
        .alloc_vk  (issue_vk),
        .alloc_qk  (issue_qk),
        .has_free  (m_free),
        .free_tag  (m_free_tag),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_value (cdb_value),
        .unit_idle (m_idle),
        .disp_valid(mul_disp_valid),
        .disp_tag  (mul_disp_tag),
        .disp_op   (m_op),
        .disp_a    (m_a),
        .disp_b    (m_b)
    );

    fu_unit #(
        .DW(DW), .TW(TW), .MULDIV(1'b0),
        .LAT_A(LAT_ADD), .LAT_M(LAT_MUL), .LAT_D(LAT_DIV)
    ) u_add_fu (
        .clk      (clk),
        .rst      (rst),
        .start    (add_disp_valid),
        .op       (a_op),
        .a        (a_a),
        .b        (a_b),
        .tag      (add_disp_tag),
        .grant    (a_grant),
        .idle     (a_idle),
        .done     (a_done),
        .res_tag  (a_res_tag),
        .res_value(a_res_val)
    );

    fu_unit #(
        .DW(DW), .TW(TW), .MULDIV(1'b1),
        .LAT_A(LAT_ADD), .LAT_M(LAT_MUL), .LAT_D(LAT_DIV)
    ) u_mul_fu (
        .clk      (clk),
        .rst      (rst),
        .start    (mul_disp_valid),
        .op       (m_op),
        .a        (m_a),
        .b        (m_b),
        .tag      (mul_disp_tag),
        .grant    (m_grant),
        .idle     (m_idle),
        .done     (m_done),
        .res_tag  (m_res_tag),
        .res_value(m_res_val)
    );

    // Single result bus: lower tag wins a tie, loser keeps its result.
    assign pick_add  = a_done && (!m_done || (a_res_tag < m_res_tag));
    assign a_grant   = pick_add;
    assign m_grant   = m_done && !pick_add;
    assign cdb_valid = a_done || m_done;
    assign cdb_tag   = pick_add ? a_res_tag : m_res_tag;
    assign cdb_value = pick_add ? a_res_val : m_res_val;

endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
    parameter int N_ADD   = 3,
    parameter int N_MUL   = 2,
    parameter int TW      = 3,
    parameter int LAT_ADD = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          issue_ready,
    input logic [1:0]    issue_op,
    input logic [TW-1:0] issue_tag,
    input logic          add_disp_valid,
    input logic [TW-1:0] add_disp_tag,
    input logic          mul_disp_valid,
    input logic          cdb_valid,
    input logic [TW-1:0] cdb_tag
);

    logic          in_flight;
    logic [15:0]   age;
    logic [TW-1:0] fl_tag;

    // Tracks cycles since the last add-class dispatch.
    always_ff @(posedge clk) begin
        if (rst) begin
            in_flight <= 1'b0;
            age       <= '0;
            fl_tag    <= '0;
        end else if (add_disp_valid) begin
            in_flight <= 1'b1;
            age       <= 16'd1;
            fl_tag    <= add_disp_tag;
        end else if (in_flight) begin
            if (age != 16'hFFFF) begin
                age <= age + 16'd1;
            end
            if (cdb_valid && cdb_tag == fl_tag) begin
                in_flight <= 1'b0;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cdb_valid && !add_disp_valid && !mul_disp_valid));

    assert_issue_tag_range_R2: assert property (@(posedge clk) disable iff (rst)
        (issue_ready && !issue_op[1]) |-> (issue_tag >= 1 && issue_tag <= TW'(N_ADD)));

    assert_add_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (in_flight && cdb_valid && cdb_tag == fl_tag) |-> (age >= 16'(LAT_ADD)));

    assert_add_nonpipe_R8: assert property (@(posedge clk) disable iff (rst)
        add_disp_valid |=> !add_disp_valid);

    assert_mul_nonpipe_R8: assert property (@(posedge clk) disable iff (rst)
        mul_disp_valid |=> !mul_disp_valid);

    assert_cdb_tag_valid_R9: assert property (@(posedge clk) disable iff (rst)
        cdb_valid |-> (cdb_tag != '0 && cdb_tag <= TW'(N_ADD + N_MUL)));

endmodule

bind rs_pool rsp_checker #(
    .N_ADD(N_ADD), .N_MUL(N_MUL), .TW(TW), .LAT_ADD(LAT_ADD)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .issue_ready   (issue_ready),
    .issue_op      (issue_op),
    .issue_tag     (issue_tag),
    .add_disp_valid(add_disp_valid),
    .add_disp_tag  (add_disp_tag),
    .mul_disp_valid(mul_disp_valid),
    .cdb_valid     (cdb_valid),
    .cdb_tag       (cdb_tag)
);

// File: tb/sim_rs_pool.sv
module sim_rs_pool;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 3;
    localparam int NM = 2;
    localparam int NT = NA + NM;
    localparam int DW = 16;
    localparam int TW = 3;
    localparam int LA = 2;
    localparam int LM = 10;
    localparam int LD = 40;

    logic          clk = 1'b0;
    logic          rst;
    logic          issue_valid;
    logic [1:0]    issue_op;
    logic [DW-1:0] issue_vj, issue_vk;
    logic [TW-1:0] issue_qj, issue_qk;
    logic          issue_ready;
    logic [TW-1:0] issue_tag;
    logic          add_disp_valid, mul_disp_valid, cdb_valid;
    logic [TW-1:0] add_disp_tag, mul_disp_tag, cdb_tag;
    logic [DW-1:0] cdb_value;

    rs_pool #(
        .N_ADD(NA), .N_MUL(NM), .DW(DW),
        .LAT_ADD(LA), .LAT_MUL(LM), .LAT_DIV(LD)
    ) u0 (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vj(issue_vj), .issue_qj(issue_qj),
        .issue_vk(issue_vk), .issue_qk(issue_qk),
        .issue_ready(issue_ready), .issue_tag(issue_tag),
        .add_disp_valid(add_disp_valid), .add_disp_tag(add_disp_tag),
        .mul_disp_valid(mul_disp_valid), .mul_disp_tag(mul_disp_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference model state (index e holds tag e+1).
    int m_busy [NT];
    int m_op   [NT];
    int m_vj   [NT];
    int m_vk   [NT];
    int m_qj   [NT];
    int m_qk   [NT];
    int m_sent [NT];
    int m_seq  [NT];
    int seq_ctr = 0;
    int u_busy [2];
    int u_cnt  [2];
    int u_tag  [2];
    int u_res  [2];

    int cyc = 0;
    int disp_cyc [1:NT];
    int cdb_cyc  [1:NT];
    int cdb_val  [1:NT];
    int cdb_count = 0;
    bit obs_ready;

    localparam int ADD = 0, SUB = 1, MUL = 2, DIV = 3;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int calc(input int op, input int a, input int b);
        longint p;
        case (op)
            ADD: return (a + b) & 16'hFFFF;
            SUB: return (a - b) & 16'hFFFF;
            MUL: begin
                p = longint'(a) * longint'(b);
                return int'(p & 64'hFFFF);
            end
            default: return (b == 0) ? 16'hFFFF : (a / b);
        endcase
    endfunction

    function automatic int lat_of(input int op);
        if (op == MUL) return LM;
        if (op == DIV) return LD;
        return LA;
    endfunction

    task automatic model_reset();
        for (int e = 0; e < NT; e++) begin
            m_busy[e] = 0; m_sent[e] = 0; m_qj[e] = 0; m_qk[e] = 0;
            m_vj[e] = 0; m_vk[e] = 0; m_op[e] = 0; m_seq[e] = 0;
        end
        for (int u = 0; u < 2; u++) begin
            u_busy[u] = 0; u_cnt[u] = 0; u_tag[u] = 0; u_res[u] = 0;
        end
    endtask

    // One clock cycle: drive, compare against the model, advance the model.
    task automatic step(input bit v, input int op, input int vj, input int qj,
                        input int vk, input int qk);
        bit e_cdb;
        int e_ctag, e_cval, e_cu;
        bit e_dv [2];
        int e_de [2];
        int cls, lo, hi, fe;
        @(negedge clk);
        issue_valid = v;
        issue_op    = op[1:0];
        issue_vj    = vj[DW-1:0];
        issue_qj    = qj[TW-1:0];
        issue_vk    = vk[DW-1:0];
        issue_qk    = qk[TW-1:0];
        #1;
        e_cdb = 0; e_ctag = 0; e_cval = 0; e_cu = -1;
        for (int u = 0; u < 2; u++) begin
            if (u_busy[u] != 0 && u_cnt[u] == 0) begin
                if (!e_cdb || u_tag[u] < e_ctag) begin
                    e_cdb = 1; e_ctag = u_tag[u]; e_cval = u_res[u]; e_cu = u;
                end
            end
        end
        for (int c = 0; c < 2; c++) begin
            e_dv[c] = 0; e_de[c] = 0;
            lo = (c == 0) ? 0 : NA;
            hi = (c == 0) ? NA : NT;
            if (u_busy[c] == 0) begin
                for (int e = lo; e < hi; e++) begin
                    if (m_busy[e] != 0 && m_sent[e] == 0 && m_qj[e] == 0 && m_qk[e] == 0) begin
                        if (!e_dv[c] || m_seq[e] < m_seq[e_de[c]]) begin
                            e_dv[c] = 1; e_de[c] = e;
                        end
                    end
                end
            end
        end
        cls = (op >= MUL) ? 1 : 0;
        lo = (cls == 0) ? 0 : NA;
        hi = (cls == 0) ? NA : NT;
        fe = -1;
        for (int e = lo; e < hi; e++) begin
            if (m_busy[e] == 0 && fe < 0) fe = e;
        end

        chk("R3", "issue_ready", int'(issue_ready), (fe >= 0) ? 1 : 0);
        chk("R2", "issue_tag", int'(issue_tag), (fe >= 0) ? fe + 1 : 0);
        chk("R6", "add_disp_valid", int'(add_disp_valid), int'(e_dv[0]));
        if (e_dv[0]) chk("R6", "add_disp_tag", int'(add_disp_tag), e_de[0] + 1);
        chk("R13", "mul_disp_valid", int'(mul_disp_valid), int'(e_dv[1]));
        if (e_dv[1]) chk("R6", "mul_disp_tag", int'(mul_disp_tag), e_de[1] + 1);
        chk("R9", "cdb_valid", int'(cdb_valid), int'(e_cdb));
        if (e_cdb) begin
            chk("R9", "cdb_tag", int'(cdb_tag), e_ctag);
            chk("R11", "cdb_value", int'(cdb_value), e_cval);
        end

        obs_ready = issue_ready;
        if (add_disp_valid) disp_cyc[int'(add_disp_tag)] = cyc;
        if (mul_disp_valid) disp_cyc[int'(mul_disp_tag)] = cyc;
        if (cdb_valid && cdb_tag != 0) begin
            cdb_cyc[int'(cdb_tag)] = cyc;
            cdb_val[int'(cdb_tag)] = int'(cdb_value);
            cdb_count++;
        end

        for (int u = 0; u < 2; u++) begin
            if (e_cu == u) u_busy[u] = 0;
            else if (u_busy[u] != 0 && u_cnt[u] > 0) u_cnt[u]--;
        end
        if (e_cdb) begin
            for (int e = 0; e < NT; e++) begin
                if (m_busy[e] != 0) begin
                    if (e + 1 == e_ctag) m_busy[e] = 0;
                    if (m_qj[e] == e_ctag) begin m_vj[e] = e_cval; m_qj[e] = 0; end
                    if (m_qk[e] == e_ctag) begin m_vk[e] = e_cval; m_qk[e] = 0; end
                end
            end
        end
        for (int c = 0; c < 2; c++) begin
            if (e_dv[c]) begin
                m_sent[e_de[c]] = 1;
                u_busy[c] = 1;
                u_cnt[c]  = lat_of(m_op[e_de[c]]) - 1;
                u_tag[c]  = e_de[c] + 1;
                u_res[c]  = calc(m_op[e_de[c]], m_vj[e_de[c]], m_vk[e_de[c]]);
            end
        end
        if (v && fe >= 0) begin
            m_busy[fe] = 1; m_sent[fe] = 0; m_op[fe] = op;
            m_seq[fe] = seq_ctr; seq_ctr++;
            if (qj != 0 && e_cdb && qj == e_ctag) begin m_vj[fe] = e_cval; m_qj[fe] = 0; end
            else begin m_vj[fe] = vj & 16'hFFFF; m_qj[fe] = qj; end
            if (qk != 0 && e_cdb && qk == e_ctag) begin m_vk[fe] = e_cval; m_qk[fe] = 0; end
            else begin m_vk[fe] = vk & 16'hFFFF; m_qk[fe] = qk; end
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, ADD, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        int busy_tags [$];
        rst = 1'b1;
        issue_valid = 0; issue_op = 0; issue_vj = 0; issue_vk = 0; issue_qj = 0; issue_qk = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        step(0, ADD, 0, 0, 0, 0);
        chk("R1", "issue_ready add after reset", int'(obs_ready), 1);
        step(0, DIV, 0, 0, 0, 0);
        chk("R1", "issue_ready div after reset", int'(obs_ready), 1);
        chk("R1", "broadcasts after reset", cdb_count, 0);

        // Independent add: R5, R7, R11
        c = cyc;
        step(1, ADD, 5, 0, 7, 0);
        idle(5);
        chk("R5", "add dispatch cycle", disp_cyc[1], c + 1);
        chk("R7", "add broadcast cycle", cdb_cyc[1], c + 3);
        chk("R11", "add value", cdb_val[1], 12);

        // Chain through the bus: R4, R5, R6, R8, R12
        c = cyc;
        step(1, MUL, 3, 0, 4, 0);          // tag4
        step(1, SUB, 0, 4, 2, 0);          // tag1
        step(1, ADD, 0, 4, 0, 4);          // tag2, both operands wait
        idle(8);
        step(1, ADD, 0, 4, 100, 0);        // tag3, issued with the broadcast
        idle(12);
        chk("R7", "mul broadcast cycle", cdb_cyc[4], c + 11);
        chk("R11", "mul value", cdb_val[4], 12);
        chk("R5", "dispatch after capture", disp_cyc[1], c + 12);
        chk("R4", "sub with captured operand", cdb_val[1], 10);
        chk("R8", "second add waits for unit", disp_cyc[2], c + 15);
        chk("R4", "both operands captured", cdb_val[2], 24);
        chk("R12", "issue-cycle capture dispatch", disp_cyc[3], c + 18);
        chk("R12", "issue-cycle capture value", cdb_val[3], 112);

        // Bus conflict: R9
        c = cyc;
        step(1, MUL, 6, 0, 7, 0);          // tag4
        idle(7);
        step(1, ADD, 1, 0, 1, 0);          // tag1
        idle(6);
        chk("R9", "lower tag first", cdb_cyc[1], c + 11);
        chk("R9", "loser held one cycle", cdb_cyc[4], c + 12);
        chk("R9", "held value", cdb_val[4], 42);

        // Both classes dispatch together: R13
        c = cyc;
        step(1, MUL, 2, 0, 3, 0);          // tag4
        step(1, ADD, 0, 4, 1, 0);          // tag1
        step(1, MUL, 0, 4, 5, 0);          // tag5
        idle(22);
        chk("R13", "add-class dispatch", disp_cyc[1], c + 12);
        chk("R13", "mul-class dispatch same cycle", disp_cyc[5], c + 12);
        chk("R7", "second mul broadcast", cdb_cyc[5], c + 22);
        chk("R11", "second mul value", cdb_val[5], 30);

        // Oldest first with younger in lower slot: R6
        c = cyc;
        step(1, MUL, 1, 0, 1, 0);          // tag4
        step(1, ADD, 0, 0, 0, 0);          // tag1, frees at c+4
        step(1, ADD, 0, 4, 20, 0);         // tag2
        idle(2);
        step(1, ADD, 0, 4, 10, 0);         // tag1 again, younger
        idle(16);
        chk("R6", "older entry dispatches first", disp_cyc[2], c + 12);
        chk("R6", "younger entry follows", disp_cyc[1], c + 15);
        chk("R6", "older value", cdb_val[2], 21);
        chk("R6", "younger value", cdb_val[1], 11);

        // Full class and release at broadcast: R3, R10, R11
        c = cyc;
        cdb_count = 0;
        step(1, DIV, 100, 0, 0, 0);        // tag4
        step(1, MUL, 0, 4, 3, 0);          // tag5
        step(1, MUL, 1, 0, 1, 0);          // dropped
        chk("R3", "stall when class full", int'(obs_ready), 0);
        idle(38);
        step(0, MUL, 0, 0, 0, 0);          // cycle c+41, broadcast of tag4
        chk("R10", "still occupied in broadcast cycle", int'(obs_ready), 0);
        step(0, MUL, 0, 0, 0, 0);          // cycle c+42
        chk("R10", "free after broadcast", int'(obs_ready), 1);
        idle(12);
        chk("R7", "divide broadcast cycle", cdb_cyc[4], c + 41);
        chk("R11", "divide by zero", cdb_val[4], 65535);
        chk("R11", "mul wraps", cdb_val[5], 65533);
        chk("R3", "dropped issue produced nothing", cdb_count, 2);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int rop, rqj, rqk;
            busy_tags.delete();
            for (int e = 0; e < NT; e++) if (m_busy[e] != 0) busy_tags.push_back(e + 1);
            rop = $urandom_range(0, 3);
            rqj = 0; rqk = 0;
            if (busy_tags.size() > 0 && $urandom_range(0, 1) == 1)
                rqj = busy_tags[$urandom_range(0, busy_tags.size() - 1)];
            if (busy_tags.size() > 0 && $urandom_range(0, 2) == 2)
                rqk = busy_tags[$urandom_range(0, busy_tags.size() - 1)];
            step($urandom_range(0, 1) == 1, rop, $urandom_range(0, 65535), rqj,
                 $urandom_range(0, 300), rqk);
        end
        idle(150);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule